// File: doc/BRIEF.md
# DDR2 Write Burst Data Sequencer

This block sits on the controller side of a DDR2 write path. It takes accepted WRITE commands, each carrying a tag and a base word index, and turns them into data beats. It also produces a strobe enable. Beats leave the block as one pair per clock: the even beat goes with the rising strobe edge and the odd beat with the falling edge. No double-data-rate I/O is needed inside the block. Data for a command starts a fixed write latency after the command. A full burst is eight beats, carried over four clocks.

A WRITE issued exactly two clocks after the previous accepted WRITE interrupts it. The earlier burst is cut after its first four beats, and the new eight-beat burst follows in the next clock with no gap. The strobe enable stays high across the join. A WRITE whose spacing would make bursts collide is refused and flagged. Each burst that finishes reports its tag and whether it was cut short.

Top module: `wburst_seq`

## Requirements
- R1: While reset is held and right after it, dqsEn, beatValid, wrErr and doneValid are 0, and beatEven, beatOdd, beatTag and doneTag are 0.
- R2: A WRITE accepted in clock cycle t puts its first beat pair on the outputs in cycle t+WL (WL defaults to 3).
- R3: Pair k (k = 0..3) of a burst with base b carries b+2k on beatEven and b+2k+1 on beatOdd, modulo 2^IDX_W. beatTag carries the command's tag.
- R4: An isolated WRITE keeps beatValid and dqsEn high for exactly 4 consecutive clocks (8 beats), and both fall afterwards.
- R5: A WRITE accepted exactly 2 cycles after the previous accepted WRITE cuts the earlier burst to pairs 0 and 1. The new burst's 4 pairs follow in the next clock, and dqsEn stays high with no idle clock between the bursts.
- R6: A WRITE that arrives 1 or 3 cycles after the last accepted WRITE is dropped. wrErr is high for one cycle in the following cycle, and the beat outputs are exactly as if that WRITE had not come. Spacing is always counted from the last accepted WRITE.
- R7: In the cycle after a burst's last pair, doneValid is high for one cycle. doneTag carries that burst's tag, and doneTrunc is 1 exactly when the burst was cut to 4 beats.
- R8: In any cycle where beatValid is 0, beatEven, beatOdd and beatTag are 0.
- R9: A WRITE that arrives 4 or more cycles after the previous one does not cut it short. At a spacing of exactly 4, the two bursts' pairs run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | WRITE command present this cycle |
| wrTag | input | TAG_W | Tag of the command |
| wrBase | input | IDX_W | Base word index of the command |
| dqsEn | output | 1 | Strobe drive enable |
| beatValid | output | 1 | A beat pair is on the outputs |
| beatEven | output | IDX_W | Word index of the rising-edge beat |
| beatOdd | output | IDX_W | Word index of the falling-edge beat |
| beatTag | output | TAG_W | Tag of the burst being sent |
| wrErr | output | 1 | Pulse: a WRITE was refused for its spacing |
| doneValid | output | 1 | Pulse: a burst has completed |
| doneTag | output | TAG_W | Tag of the completed burst |
| doneTrunc | output | 1 | The completed burst was cut to 4 beats |

## Verification
Suppose the spacing counter holds a wrong value. The ports then show it within one clock of the next WRITE: either wrErr fires on a legal command, or the beat count of the running burst is wrong about WL clocks later. Suppose the burst counter or the index register goes astray. The beatEven/beatOdd sequence is then off on the very next pair. The done pulse also lands a cycle early or late, or with the wrong truncation flag.

// File: rtl/wburst_pkg.sv
package wburst_pkg;
  typedef struct packed {
    logic load;    // start a new burst from the launch stage
    logic step;    // advance the running burst by one pair
    logic finish;  // the running burst ends at this edge
  } wbsStrobe_t;
endpackage

// File: rtl/wburst_ctrl.sv
module wburst_ctrl
  import wburst_pkg::*;
#(
  parameter int WL = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  output wbsStrobe_t strobe,
  output logic       active,
  output logic       errPulse,
  output logic       doneValid,
  output logic       doneTrunc
);
  localparam logic [2:0] GAP_FAR = 3'd4;
  localparam logic [1:0] LAST_PAIR = 2'd3;

  logic [2:0] sinceLast;
  logic       accept;
  logic       reject;
  logic       launch;
  logic [1:0] cnt;

  // spacing since the last accepted command; 4 means four or more
  assign accept = wrValid && (sinceLast == 3'd2 || sinceLast == GAP_FAR);
  assign reject = wrValid && !accept;

  always_ff @(posedge clk) begin
    if (!rstN)              sinceLast <= GAP_FAR;
    else if (accept)        sinceLast <= 3'd1;
    else if (sinceLast != GAP_FAR) sinceLast <= sinceLast + 3'd1;
  end

  // latency alignment of the command valid bit
  generate
    if (WL == 1) begin : g_direct
      assign launch = accept;
    end else begin : g_pipe
      logic [WL-2:0] vPipe;
      always_ff @(posedge clk) begin
        if (!rstN) vPipe <= '0;
        else begin
          vPipe[0] <= accept;
          for (int i = 1; i < WL - 1; i++) vPipe[i] <= vPipe[i-1];
        end
      end
      assign launch = vPipe[WL-2];
    end
  endgenerate

  assign strobe.load   = launch;
  assign strobe.step   = active && !launch;
  assign strobe.finish = active && (cnt == LAST_PAIR || launch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      cnt       <= '0;
      errPulse  <= 1'b0;
      doneValid <= 1'b0;
      doneTrunc <= 1'b0;
    end else begin
      errPulse  <= reject;
      doneValid <= strobe.finish;
      doneTrunc <= strobe.finish && cnt != LAST_PAIR;
      if (launch) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == LAST_PAIR) active <= 1'b0;
        cnt <= cnt + 2'd1;
      end
    end
  end

  // a new burst may only join a running one after pair 1 (cut) or pair 3
  p_join_r5: assert property (@(posedge clk) disable iff (!rstN)
    (launch && active) |-> (cnt == 2'd1 || cnt == LAST_PAIR));
  p_seam_r5: assert property (@(posedge clk) disable iff (!rstN)
    (launch && active) |=> (active && cnt == 2'd0));
  p_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && cnt == LAST_PAIR && !launch) |=> !active);
  p_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(wrValid));
  p_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(active));
endmodule

// File: rtl/wburst_dpath.sv
module wburst_dpath
  import wburst_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int IDX_W = 8,
  parameter int WL    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [IDX_W-1:0] wrBase,
  input  wbsStrobe_t       strobe,
  input  logic             active,
  output logic [IDX_W-1:0] beatEven,
  output logic [IDX_W-1:0] beatOdd,
  output logic [TAG_W-1:0] beatTag,
  output logic [TAG_W-1:0] doneTag
);
  localparam logic [IDX_W-1:0] PAIR_STEP = IDX_W'(2);

  logic [TAG_W-1:0] launchTag;
  logic [IDX_W-1:0] launchBase;
  logic [TAG_W-1:0] curTag;
  logic [IDX_W-1:0] curIdx;

  generate
    if (WL == 1) begin : g_direct
      assign launchTag  = wrTag;
      assign launchBase = wrBase;
    end else begin : g_pipe
      logic [TAG_W-1:0] tPipe [WL-1];
      logic [IDX_W-1:0] bPipe [WL-1];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < WL - 1; i++) begin
            tPipe[i] <= '0;
            bPipe[i] <= '0;
          end
        end else begin
          tPipe[0] <= wrTag;
          bPipe[0] <= wrBase;
          for (int i = 1; i < WL - 1; i++) begin
            tPipe[i] <= tPipe[i-1];
            bPipe[i] <= bPipe[i-1];
          end
        end
      end
      assign launchTag  = tPipe[WL-2];
      assign launchBase = bPipe[WL-2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTag  <= '0;
      curIdx  <= '0;
      doneTag <= '0;
    end else begin
      doneTag <= strobe.finish ? curTag : '0;
      if (strobe.load) begin
        curTag <= launchTag;
        curIdx <= launchBase;
      end else if (strobe.step) begin
        curIdx <= curIdx + PAIR_STEP;
      end
    end
  end

  assign beatEven = active ? curIdx : '0;
  assign beatOdd  = active ? curIdx + IDX_W'(1) : '0;
  assign beatTag  = active ? curTag : '0;
endmodule

// File: rtl/wburst_seq.sv
module wburst_seq
  import wburst_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int IDX_W = 8,
  parameter int WL    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [IDX_W-1:0] wrBase,
  output logic             dqsEn,
  output logic             beatValid,
  output logic [IDX_W-1:0] beatEven,
  output logic [IDX_W-1:0] beatOdd,
  output logic [TAG_W-1:0] beatTag,
  output logic             wrErr,
  output logic             doneValid,
  output logic [TAG_W-1:0] doneTag,
  output logic             doneTrunc
);
  wbsStrobe_t strobe;
  logic       active;

  wburst_ctrl #(.WL(WL)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .strobe    (strobe),
    .active    (active),
    .errPulse  (wrErr),
    .doneValid (doneValid),
    .doneTrunc (doneTrunc)
  );

  wburst_dpath #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WL(WL)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .wrTag    (wrTag),
    .wrBase   (wrBase),
    .strobe   (strobe),
    .active   (active),
    .beatEven (beatEven),
    .beatOdd  (beatOdd),
    .beatTag  (beatTag),
    .doneTag  (doneTag)
  );

  assign dqsEn     = active;
  assign beatValid = active;
endmodule

// File: tb/wburst_seq_bench.sv
module wburst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4;
  localparam int IDX_W = 8;
  localparam int WL    = 3;
  localparam int NVEC  = 8;
  // {gap to second write (0 = none), tagA, baseA, tagB, baseB}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0, 4'd1,  8'd10,  4'd0,  8'd0},
    {8'd0, 4'd2,  8'hFC,  4'd0,  8'd0},
    {8'd2, 4'd3,  8'd20,  4'd4,  8'd40},
    {8'd1, 4'd5,  8'd50,  4'd6,  8'd60},
    {8'd3, 4'd7,  8'd70,  4'd8,  8'd80},
    {8'd4, 4'd9,  8'd90,  4'd10, 8'd100},
    {8'd6, 4'd11, 8'd0,   4'd12, 8'd200},
    {8'd2, 4'd15, 8'hFE,  4'd14, 8'hF0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [TAG_W-1:0] wrTag = '0;
  logic [IDX_W-1:0] wrBase = '0;
  logic dqsEn, beatValid, wrErr, doneValid, doneTrunc;
  logic [IDX_W-1:0] beatEven, beatOdd;
  logic [TAG_W-1:0] beatTag, doneTag;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wburst_seq #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WL(WL)) u_wburst_seq (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrTag(wrTag), .wrBase(wrBase),
    .dqsEn(dqsEn), .beatValid(beatValid), .beatEven(beatEven), .beatOdd(beatOdd),
    .beatTag(beatTag), .wrErr(wrErr), .doneValid(doneValid), .doneTag(doneTag),
    .doneTrunc(doneTrunc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    chk("R1 dqsEn", dqsEn, 0);
    chk("R1 beatValid", beatValid, 0);
    chk("R1 outputs", {beatEven, beatOdd, beatTag, wrErr, doneValid, doneTag, doneTrunc}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {beatValid, beatEven, wrErr, doneValid}, 0);

    for (int v = 0; v < NVEC; v++) begin
      int g, nA;
      logic [TAG_W-1:0] tA, tB;
      logic [IDX_W-1:0] bA, bB;
      bit accB, errB;
      string rq;
      g = int'(VEC[v][31:24]);
      tA = VEC[v][23:20]; bA = VEC[v][19:12];
      tB = VEC[v][11:8];  bB = VEC[v][7:0];
      accB = (g == 2) || (g >= 4);
      errB = (g == 1) || (g == 3);
      nA = (g == 2) ? 2 : 4;
      rq = (g == 0) ? "R4" : (g == 2) ? "R5" : errB ? "R6" : "R9";
      for (int c = 0; c <= g + WL + 8; c++) begin
        logic eV, eDone, eTr, eErr;
        logic [IDX_W-1:0] eE;
        logic [TAG_W-1:0] eT, eDT;
        @(negedge clk);
        eV = 0; eE = '0; eT = '0; eDone = 0; eDT = '0; eTr = 0;
        eErr = errB && (c == g + 1);
        if (c >= WL && c < WL + nA) begin
          eV = 1; eE = bA + IDX_W'(2 * (c - WL)); eT = tA;
        end
        if (accB && c >= g + WL && c < g + WL + 4) begin
          eV = 1; eE = bB + IDX_W'(2 * (c - g - WL)); eT = tB;
        end
        if (c == WL + nA) begin eDone = 1; eDT = tA; eTr = (g == 2); end
        if (accB && c == g + WL + 4) begin eDone = 1; eDT = tB; eTr = 0; end
        if (c == WL) chk("R2 first pair", beatValid, 1);
        chk({rq, " valid"}, beatValid, eV);
        chk({rq, " dqsEn"}, dqsEn, eV);
        if (eV) begin
          chk("R3 even", beatEven, eE);
          chk("R3 odd", beatOdd, eE + IDX_W'(1));
          chk("R3 tag", beatTag, eT);
        end else begin
          chk("R8 idle zero", {beatEven, beatOdd, beatTag}, 0);
        end
        chk("R7 done", doneValid, eDone);
        chk("R7 doneTag", doneTag, eDT);
        chk("R7 doneTrunc", doneTrunc, eTr);
        chk("R6 wrErr", wrErr, eErr);
        wrValid = (c == 0) || (g != 0 && c == g);
        wrTag   = (c == 0) ? tA : tB;
        wrBase  = (c == 0) ? bA : bB;
      end
      wrValid = 1'b0;
    end

    // Directed: chained cuts, writes at 0, 2, 4; middle burst is also cut (R5)
    for (int c = 0; c <= 14; c++) begin
      @(negedge clk);
      if (c == WL + 2) begin
        chk("R5 chain doneA trunc", {doneValid, doneTag, doneTrunc}, {1'b1, 4'd1, 1'b1});
        chk("R5 chain B start", beatEven, 8'd30);
      end
      if (c == WL + 4) begin
        chk("R5 chain doneB trunc", {doneValid, doneTag, doneTrunc}, {1'b1, 4'd2, 1'b1});
        chk("R5 chain C start", {beatValid, beatEven, beatTag}, {1'b1, 8'd60, 4'd3});
      end
      if (c == WL + 7) chk("R5 chain C last", beatOdd, 8'd67);
      if (c == WL + 8) chk("R7 chain doneC", {doneValid, doneTag, doneTrunc}, {1'b1, 4'd3, 1'b0});
      wrValid = (c == 0) || (c == 2) || (c == 4);
      wrTag   = TAG_W'(c / 2 + 1);
      wrBase  = IDX_W'(c * 15);
    end
    wrValid = 1'b0;

    // Directed: reset mid-burst returns to quiet outputs (R1)
    @(negedge clk); wrValid = 1'b1; wrBase = 8'd5;
    @(negedge clk); wrValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-burst", {dqsEn, beatValid, beatEven, doneValid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule